// File: doc/BRIEF.md
# Software-Start DMA Request Arbiter

This block sits between a CPU register write port and a DMA transfer engine. A CPU write asks for a software-started transfer and carries a descriptor pointer. The block accepts the write only when it can take it. It keeps the pointer, holds a pending flag, and arbitrates the software request against a hardware-triggered request. A configuration bit picks the winner when both are waiting. The winner is issued to the engine as a single grant carrying the descriptor pointer. At most one grant is outstanding at any time.

The engine fetches descriptors and moves the data. It is outside this block and answers each grant with a done or error pulse. With the done pulse it also returns chain, lock, interrupt-flag and next-pointer information. A locked chain continues at once on the same source. An unlocked chain goes back to arbitration. Errors are logged in a small record. If error-stop is enabled, a software grant is withheld until the CPU issues an error-clear command.

Top module: `sw_start_arb`

## Requirements
- R1: After reset, `gnt_valid_o`, `sw_pend_o`, `sw_done_o`, `err_stop_o`, `err_valid_o` and `err_dbl_o` are 0, and `sw_desc_o` is 0.
- R2: A write on `sw_wr_i` is rejected when a software request is already pending, when the error-stop flag is set, or when `cmd_i` is not 2'b00. A rejected write leaves `sw_pend_o`, `sw_done_o` and `sw_desc_o` unchanged.
- R3: An accepted write sets `sw_pend_o`, clears `sw_done_o` and stores `sw_desc_i` into `sw_desc_o` on the next clock edge.
- R4: Only one grant is outstanding at a time. Once `gnt_valid_o` rises, it stays high with `gnt_sw_o` and `gnt_desc_o` unchanged until `eng_done_i` or `eng_err_i` is seen. A new grant is never issued in the cycle that the response arrives.
- R5: When no chain is forced, a pending software request and a hardware request are arbitrated by `cfg_sw_prio_i`: 1 grants the software request (`gnt_sw_o`=1, descriptor `sw_desc_o`), 0 grants the hardware request (`gnt_sw_o`=0, descriptor `hw_desc_i`). A lone request is granted whatever the setting.
- R6: When a hardware grant completes with `eng_chain_i`=1 and `eng_lock_i`=1, the next grant is a hardware grant carrying `eng_next_desc_i`. It is issued two edges after the done pulse, ahead of any pending software request.
- R7: When a hardware grant completes with a chain that is not locked, the next grant is decided by normal arbitration (R5).
- R8: When a software grant completes with `eng_chain_i`=1, `sw_desc_o` is reloaded with `eng_next_desc_i` and the request stays pending. If `eng_lock_i`=1, the next grant is software with that pointer. Otherwise normal arbitration applies.
- R9: When a software grant completes without chain or error, `sw_pend_o` clears. `sw_done_o` is set only if `eng_irq_i` was 1 with the done pulse.
- R10: The first error after a clear records the grant's source (`err_sw_o`) and descriptor (`err_desc_o`) and sets `err_valid_o`. A further error while a record is held sets `err_dbl_o` and keeps the record. A software error clears `sw_pend_o`.
- R11: With `cfg_stop_en_i`=1, an error sets `err_stop_o`. While it is set, no software grant is issued. `cmd_i`=2'b01 for one cycle clears `err_stop_o`, `err_valid_o` and `err_dbl_o`, after which a pending software request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sw_prio_i | input | 1 | 1: software wins arbitration, 0: hardware wins |
| cfg_stop_en_i | input | 1 | Errors raise the error-stop flag |
| cmd_i | input | 2 | CPU command field; 00 none, 01 error clear |
| sw_wr_i | input | 1 | CPU software-start write strobe |
| sw_desc_i | input | DW | Descriptor pointer carried by the write |
| hw_req_i | input | 1 | Hardware transfer request, held until granted |
| hw_desc_i | input | DW | Descriptor pointer of the hardware request |
| gnt_valid_o | output | 1 | Grant outstanding to the engine |
| gnt_sw_o | output | 1 | Grant belongs to the software request |
| gnt_desc_o | output | DW | Descriptor pointer of the grant |
| eng_done_i | input | 1 | Engine finished the descriptor normally |
| eng_err_i | input | 1 | Engine finished the descriptor with an error |
| eng_chain_i | input | 1 | Finished descriptor has a chained successor |
| eng_lock_i | input | 1 | Chained successor is locked |
| eng_irq_i | input | 1 | Finished descriptor asks for the done flag |
| eng_next_desc_i | input | DW | Pointer of the chained successor |
| sw_pend_o | output | 1 | Software request pending |
| sw_done_o | output | 1 | Software transfer done flag |
| sw_desc_o | output | DW | Stored software descriptor pointer |
| err_stop_o | output | 1 | Error-stop flag |
| err_valid_o | output | 1 | Error record held |
| err_sw_o | output | 1 | Recorded error came from a software grant |
| err_desc_o | output | DW | Descriptor pointer of the recorded error |
| err_dbl_o | output | 1 | A further error occurred while a record was held |

## Verification
The hardest states to reach are those where a software request is already pending when a chained or failed hardware descriptor finishes. A plain sequence of writes never gets there, because the pending software request would simply be granted first. The stimulus therefore starts a hardware grant, then makes the CPU write while the engine is still busy. The completion then carries chain and lock, or an error with stop enabled. This shows the locked successor, or the withheld software grant, before the software request is served.

// File: rtl/sw_arb_pkg.sv
package sw_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  localparam logic [1:0] CMD_NONE    = 2'b00;
  localparam logic [1:0] CMD_ERR_CLR = 2'b01;
endpackage

// File: rtl/sw_req_reg.sv
module sw_req_reg
  import sw_arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_wr_i,
  input  logic [DW-1:0] sw_desc_i,
  input  logic [1:0]    cmd_i,
  input  logic          err_stop_i,
  input  logic          fin_sw_i,
  input  logic          fin_irq_i,
  input  logic          sw_err_i,
  input  logic          reload_i,
  input  logic [DW-1:0] reload_desc_i,
  output logic          pend_o,
  output logic          done_o,
  output logic [DW-1:0] desc_o
);
  logic accept;

  assign accept = sw_wr_i && !pend_o && !err_stop_i && (cmd_i == CMD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      done_o <= 1'b0;
      desc_o <= '0;
    end else begin
      if (accept) begin
        pend_o <= 1'b1;
        done_o <= 1'b0;
        desc_o <= sw_desc_i;
      end else begin
        if (fin_sw_i || sw_err_i) pend_o <= 1'b0;
        if (fin_sw_i && fin_irq_i) done_o <= 1'b1;
        if (reload_i) desc_o <= reload_desc_i;
      end
    end
  end

  AST_ACCEPT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && !pend_o && !err_stop_i && cmd_i == CMD_NONE)
    |=> (pend_o && !done_o && desc_o == $past(sw_desc_i))); // R3

  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && pend_o && !reload_i && !fin_sw_i && !sw_err_i)
    |=> ($stable(desc_o) && pend_o)); // R2

  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_sw_i && !sw_wr_i) |=> (!pend_o && (done_o == ($past(fin_irq_i) || $past(done_o))))); // R9
endmodule

// File: rtl/err_mon.sv
module err_mon #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_err_i,
  input  logic          ev_sw_i,
  input  logic [DW-1:0] ev_desc_i,
  input  logic          stop_en_i,
  input  logic          clr_i,
  output logic          stop_o,
  output logic          valid_o,
  output logic          sw_o,
  output logic [DW-1:0] desc_o,
  output logic          dbl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o  <= 1'b0;
      valid_o <= 1'b0;
      sw_o    <= 1'b0;
      desc_o  <= '0;
      dbl_o   <= 1'b0;
    end else if (clr_i) begin
      stop_o  <= 1'b0;
      valid_o <= 1'b0;
      dbl_o   <= 1'b0;
    end else if (ev_err_i) begin
      if (stop_en_i) stop_o <= 1'b1;
      if (!valid_o) begin
        valid_o <= 1'b1;
        sw_o    <= ev_sw_i;
        desc_o  <= ev_desc_i;
      end else begin
        dbl_o <= 1'b1;
      end
    end
  end

  AST_FIRST_ERR_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_err_i && !valid_o && !clr_i) |=> (valid_o && desc_o == $past(ev_desc_i))); // R10

  AST_DOUBLE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_err_i && valid_o && !clr_i) |=> (dbl_o && $stable(desc_o))); // R10

  AST_STOP_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_err_i && stop_en_i && !clr_i) |=> stop_o); // R11

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!stop_o && !valid_o && !dbl_o)); // R11
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import sw_arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_sw_prio_i,
  input  logic          sw_pend_i,
  input  logic [DW-1:0] sw_desc_i,
  input  logic          err_stop_i,
  input  logic          hw_req_i,
  input  logic [DW-1:0] hw_desc_i,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  input  logic          eng_chain_i,
  input  logic          eng_lock_i,
  input  logic          eng_irq_i,
  input  logic [DW-1:0] eng_next_desc_i,
  output logic          gnt_valid_o,
  output logic          gnt_sw_o,
  output logic [DW-1:0] gnt_desc_o,
  output logic          fin_sw_o,
  output logic          fin_irq_o,
  output logic          reload_o,
  output logic [DW-1:0] reload_desc_o,
  output logic          ev_err_o,
  output logic          ev_sw_o,
  output logic [DW-1:0] ev_desc_o
);
  arb_state_e    state_q;
  logic          gnt_sw_q;
  logic [DW-1:0] gnt_desc_q;
  logic          chain_q;
  logic          chain_sw_q;
  logic [DW-1:0] chain_desc_q;

  logic          rsp_err, rsp_done, is_idle;
  logic          sw_go, hw_go, issue;
  logic          pick_sw;
  logic [DW-1:0] pick_desc;

  assign is_idle  = (state_q == ARB_IDLE);
  assign rsp_err  = !is_idle && eng_err_i;
  assign rsp_done = !is_idle && eng_done_i && !eng_err_i;

  // software is held while error-stop is set
  assign sw_go = sw_pend_i && !err_stop_i && (cfg_sw_prio_i || !hw_req_i);
  assign hw_go = hw_req_i;
  assign issue = is_idle && (chain_q || sw_go || hw_go);

  always_comb begin
    if (chain_q) begin
      pick_sw   = chain_sw_q;
      pick_desc = chain_desc_q;
    end else if (sw_go) begin
      pick_sw   = 1'b1;
      pick_desc = sw_desc_i;
    end else begin
      pick_sw   = 1'b0;
      pick_desc = hw_desc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ARB_IDLE;
      gnt_sw_q     <= 1'b0;
      gnt_desc_q   <= '0;
      chain_q      <= 1'b0;
      chain_sw_q   <= 1'b0;
      chain_desc_q <= '0;
    end else if (is_idle) begin
      if (issue) begin
        state_q    <= ARB_BUSY;
        gnt_sw_q   <= pick_sw;
        gnt_desc_q <= pick_desc;
        chain_q    <= 1'b0;
      end
    end else if (rsp_err) begin
      state_q <= ARB_IDLE;
      chain_q <= 1'b0;
    end else if (rsp_done) begin
      state_q      <= ARB_IDLE;
      chain_q      <= eng_chain_i && eng_lock_i;
      chain_sw_q   <= gnt_sw_q;
      chain_desc_q <= eng_next_desc_i;
    end
  end

  assign gnt_valid_o   = !is_idle;
  assign gnt_sw_o      = gnt_sw_q;
  assign gnt_desc_o    = gnt_desc_q;

  assign fin_sw_o      = rsp_done && gnt_sw_q && !eng_chain_i;
  assign fin_irq_o     = eng_irq_i;
  assign reload_o      = rsp_done && gnt_sw_q && eng_chain_i;
  assign reload_desc_o = eng_next_desc_i;
  assign ev_err_o      = rsp_err;
  assign ev_sw_o       = gnt_sw_q;
  assign ev_desc_o     = gnt_desc_q;

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !eng_done_i && !eng_err_i)
    |=> (gnt_valid_o && $stable(gnt_sw_o) && $stable(gnt_desc_o))); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && (eng_done_i || eng_err_i)) |=> !gnt_valid_o); // R4

  AST_SW_PRIO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_idle && !chain_q && sw_pend_i && !err_stop_i && hw_req_i && cfg_sw_prio_i)
    |=> (gnt_valid_o && gnt_sw_o)); // R5

  AST_HW_LOCK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done && !gnt_sw_q && eng_chain_i && eng_lock_i)
    |=> ##1 (gnt_valid_o && !gnt_sw_o && gnt_desc_o == $past(eng_next_desc_i, 2))); // R6

  AST_STOP_HOLDS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gnt_valid_o) && gnt_sw_o) |-> !$past(err_stop_i)); // R11
endmodule

// File: rtl/sw_start_arb.sv
module sw_start_arb
  import sw_arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_sw_prio_i,
  input  logic          cfg_stop_en_i,
  input  logic [1:0]    cmd_i,
  input  logic          sw_wr_i,
  input  logic [DW-1:0] sw_desc_i,
  input  logic          hw_req_i,
  input  logic [DW-1:0] hw_desc_i,
  output logic          gnt_valid_o,
  output logic          gnt_sw_o,
  output logic [DW-1:0] gnt_desc_o,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  input  logic          eng_chain_i,
  input  logic          eng_lock_i,
  input  logic          eng_irq_i,
  input  logic [DW-1:0] eng_next_desc_i,
  output logic          sw_pend_o,
  output logic          sw_done_o,
  output logic [DW-1:0] sw_desc_o,
  output logic          err_stop_o,
  output logic          err_valid_o,
  output logic          err_sw_o,
  output logic [DW-1:0] err_desc_o,
  output logic          err_dbl_o
);
  logic          fin_sw, fin_irq, reload, ev_err, ev_sw;
  logic [DW-1:0] reload_desc, ev_desc;
  logic          err_clr;

  assign err_clr = (cmd_i == CMD_ERR_CLR);

  sw_req_reg #(.DW(DW)) u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sw_wr_i       (sw_wr_i),
    .sw_desc_i     (sw_desc_i),
    .cmd_i         (cmd_i),
    .err_stop_i    (err_stop_o),
    .fin_sw_i      (fin_sw),
    .fin_irq_i     (fin_irq),
    .sw_err_i      (ev_err && ev_sw),
    .reload_i      (reload),
    .reload_desc_i (reload_desc),
    .pend_o        (sw_pend_o),
    .done_o        (sw_done_o),
    .desc_o        (sw_desc_o)
  );

  arb_fsm #(.DW(DW)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_sw_prio_i   (cfg_sw_prio_i),
    .sw_pend_i       (sw_pend_o),
    .sw_desc_i       (sw_desc_o),
    .err_stop_i      (err_stop_o),
    .hw_req_i        (hw_req_i),
    .hw_desc_i       (hw_desc_i),
    .eng_done_i      (eng_done_i),
    .eng_err_i       (eng_err_i),
    .eng_chain_i     (eng_chain_i),
    .eng_lock_i      (eng_lock_i),
    .eng_irq_i       (eng_irq_i),
    .eng_next_desc_i (eng_next_desc_i),
    .gnt_valid_o     (gnt_valid_o),
    .gnt_sw_o        (gnt_sw_o),
    .gnt_desc_o      (gnt_desc_o),
    .fin_sw_o        (fin_sw),
    .fin_irq_o       (fin_irq),
    .reload_o        (reload),
    .reload_desc_o   (reload_desc),
    .ev_err_o        (ev_err),
    .ev_sw_o         (ev_sw),
    .ev_desc_o       (ev_desc)
  );

  err_mon #(.DW(DW)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_err_i  (ev_err),
    .ev_sw_i   (ev_sw),
    .ev_desc_i (ev_desc),
    .stop_en_i (cfg_stop_en_i),
    .clr_i     (err_clr),
    .stop_o    (err_stop_o),
    .valid_o   (err_valid_o),
    .sw_o      (err_sw_o),
    .desc_o    (err_desc_o),
    .dbl_o     (err_dbl_o)
  );
endmodule

// File: tb/sw_start_arb_tb.sv
module sw_start_arb_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sw_prio = 1'b0, cfg_stop_en = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic          sw_wr = 1'b0;
  logic [DW-1:0] sw_desc = '0;
  logic          hw_req = 1'b0;
  logic [DW-1:0] hw_desc = '0;
  logic          gnt_valid, gnt_sw;
  logic [DW-1:0] gnt_desc;
  logic          e_done = 1'b0, e_err = 1'b0, e_chain = 1'b0, e_lock = 1'b0, e_irq = 1'b0;
  logic [DW-1:0] e_next = '0;
  logic          sw_pend, sw_done, err_stop, err_valid, err_sw, err_dbl;
  logic [DW-1:0] sw_desc_q, err_desc;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sw_start_arb #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_sw_prio_i(cfg_sw_prio), .cfg_stop_en_i(cfg_stop_en), .cmd_i(cmd),
    .sw_wr_i(sw_wr), .sw_desc_i(sw_desc), .hw_req_i(hw_req), .hw_desc_i(hw_desc),
    .gnt_valid_o(gnt_valid), .gnt_sw_o(gnt_sw), .gnt_desc_o(gnt_desc),
    .eng_done_i(e_done), .eng_err_i(e_err), .eng_chain_i(e_chain), .eng_lock_i(e_lock),
    .eng_irq_i(e_irq), .eng_next_desc_i(e_next),
    .sw_pend_o(sw_pend), .sw_done_o(sw_done), .sw_desc_o(sw_desc_q),
    .err_stop_o(err_stop), .err_valid_o(err_valid), .err_sw_o(err_sw),
    .err_desc_o(err_desc), .err_dbl_o(err_dbl)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [DW-1:0] d, input logic [1:0] c);
    sw_wr = 1'b1; sw_desc = d; cmd = c;
    @(negedge clk);
    sw_wr = 1'b0; cmd = 2'b00;
  endtask

  task automatic wait_gnt(input string tag);
    int k;
    k = 0;
    while (!gnt_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " grant seen"}, DW'(gnt_valid), DW'(1));
  endtask

  task automatic respond(input logic err, input logic ch, input logic lk,
                         input logic irq, input logic [DW-1:0] nx);
    e_done = ~err; e_err = err; e_chain = ch; e_lock = lk; e_irq = irq; e_next = nx;
    @(negedge clk);
    e_done = 0; e_err = 0; e_chain = 0; e_lock = 0; e_irq = 0; e_next = '0;
  endtask

  task automatic serve_plain(input string tag);
    wait_gnt(tag);
    if (!gnt_sw) hw_req = 1'b0;
    respond(0, 0, 0, 0, '0);
  endtask

  // {cfg_sw_prio, hw_req, sw_write, expected gnt_sw}
  localparam logic [3:0] VEC [4] = '{4'b1111, 4'b0110, 4'b0011, 4'b1100};

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 gnt_valid", DW'(gnt_valid), 0);
    chk("R1 sw_pend", DW'(sw_pend), 0);
    chk("R1 sw_desc", sw_desc_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err flags", DW'({err_stop, err_valid, err_dbl, sw_done}), 0);

    // R5 arbitration table
    for (int i = 0; i < 4; i++) begin
      cfg_sw_prio = VEC[i][3];
      if (VEC[i][1]) sw_write(32'h100 + i, 2'b00);
      hw_req = VEC[i][2]; hw_desc = 32'h200 + i;
      wait_gnt("R5 table");
      chk("R5 winner source", DW'(gnt_sw), DW'(VEC[i][0]));
      chk("R5 winner desc", gnt_desc, VEC[i][0] ? 32'h100 + i : 32'h200 + i);
      if (!gnt_sw) hw_req = 1'b0;
      respond(0, 0, 0, 0, '0);
      if (sw_pend || hw_req) serve_plain("R5 drain");
    end

    // R2/R3/R4/R9 directed
    sw_write(32'hA0, 2'b00);
    chk("R3 pend after accept", DW'(sw_pend), 1);
    chk("R3 desc latched", sw_desc_q, 32'hA0);
    wait_gnt("R4");
    sw_write(32'hB0, 2'b00);
    chk("R2 pending write rejected", sw_desc_q, 32'hA0);
    repeat (3) @(negedge clk);
    chk("R4 grant held", gnt_desc, 32'hA0);
    respond(0, 0, 0, 1, '0);
    chk("R4 no grant in response cycle", DW'(gnt_valid), 0);
    chk("R9 irq sets done", DW'({sw_pend, sw_done}), 2'b01);
    sw_write(32'hC0, 2'b01);
    chk("R2 nonzero cmd rejected", DW'({sw_pend, sw_done}), 2'b01);
    chk("R2 desc kept", sw_desc_q, 32'hA0);
    sw_write(32'hD0, 2'b00);
    chk("R3 accept clears done", DW'({sw_pend, sw_done}), 2'b10);
    wait_gnt("R9");
    respond(0, 0, 0, 0, '0);
    chk("R9 no irq leaves done clear", DW'({sw_pend, sw_done}), 2'b00);

    // R6 locked hardware chain beats software priority
    cfg_sw_prio = 1'b1;
    hw_req = 1'b1; hw_desc = 32'h300;
    wait_gnt("R6 hw");
    hw_req = 1'b0;
    sw_write(32'hE0, 2'b00);
    respond(0, 1, 1, 0, 32'h310);
    @(negedge clk);
    chk("R6 successor granted", DW'(gnt_valid), 1);
    chk("R6 successor is hw", DW'(gnt_sw), 0);
    chk("R6 successor desc", gnt_desc, 32'h310);
    respond(0, 0, 0, 0, '0);
    wait_gnt("R6 sw after");
    chk("R6 sw served after chain", gnt_desc, 32'hE0);
    respond(0, 0, 0, 0, '0);

    // R7 unlocked hardware chain returns to arbitration
    hw_req = 1'b1; hw_desc = 32'h400;
    wait_gnt("R7 hw");
    hw_req = 1'b0;
    sw_write(32'hF0, 2'b00);
    respond(0, 1, 0, 0, 32'h410);
    wait_gnt("R7 next");
    chk("R7 sw wins after unlocked chain", DW'(gnt_sw), 1);
    respond(0, 0, 0, 0, '0);

    // R8 software chain
    cfg_sw_prio = 1'b0;
    sw_write(32'h500, 2'b00);
    wait_gnt("R8 sw");
    hw_req = 1'b1; hw_desc = 32'h600;
    respond(0, 1, 1, 0, 32'h510);
    chk("R8 desc reloaded", sw_desc_q, 32'h510);
    chk("R8 still pending", DW'(sw_pend), 1);
    @(negedge clk);
    chk("R8 locked sw successor", DW'({gnt_valid, gnt_sw}), 2'b11);
    chk("R8 locked sw desc", gnt_desc, 32'h510);
    respond(0, 1, 0, 0, 32'h520);
    chk("R8 unlocked reload", sw_desc_q, 32'h520);
    wait_gnt("R8 arb");
    chk("R8 hw wins after unlocked sw chain", DW'(gnt_sw), 0);
    hw_req = 1'b0;
    respond(0, 0, 0, 0, '0);
    wait_gnt("R8 tail");
    chk("R8 sw resumes at next ptr", gnt_desc, 32'h520);
    respond(0, 0, 0, 1, '0);
    chk("R9 chain end done", DW'({sw_pend, sw_done}), 2'b01);

    // R10 error record
    cfg_stop_en = 1'b0;
    hw_req = 1'b1; hw_desc = 32'h700;
    wait_gnt("R10 hw");
    hw_req = 1'b0;
    respond(1, 0, 0, 0, '0);
    chk("R10 first record", DW'({err_valid, err_sw, err_dbl, err_stop}), 4'b1000);
    chk("R10 record desc", err_desc, 32'h700);
    sw_write(32'h710, 2'b00);
    wait_gnt("R10 sw");
    respond(1, 0, 0, 0, '0);
    chk("R10 second error flags", DW'({err_valid, err_sw, err_dbl}), 3'b101);
    chk("R10 record kept", err_desc, 32'h700);
    chk("R10 sw error clears pend", DW'(sw_pend), 0);
    cmd = 2'b01; @(negedge clk); cmd = 2'b00;
    chk("R11 clear command", DW'({err_valid, err_dbl}), 0);

    // R11 error stop holds software
    cfg_stop_en = 1'b1; cfg_sw_prio = 1'b1;
    hw_req = 1'b1; hw_desc = 32'h800;
    wait_gnt("R11 hw");
    hw_req = 1'b0;
    sw_write(32'h810, 2'b00);
    respond(1, 0, 0, 0, '0);
    chk("R11 stop set", DW'(err_stop), 1);
    sw_write(32'h820, 2'b00);
    chk("R2 write rejected under stop", sw_desc_q, 32'h810);
    repeat (5) @(negedge clk);
    chk("R11 sw held", DW'(gnt_valid), 0);
    cmd = 2'b01; @(negedge clk); cmd = 2'b00;
    chk("R11 stop cleared", DW'(err_stop), 0);
    wait_gnt("R11 release");
    chk("R11 sw granted after clear", gnt_desc, 32'h810);
    respond(0, 0, 0, 0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule